// File: doc/BRIEF.md
# Bus-Master DMA Engine

This block moves dword streams between two local FIFOs and a 32-bit bus-master port that never inserts wait states. Software programs a source or destination address, a dword count for each direction and a control word. The engine then runs the job as one or more bursts. Write jobs pull data from an outbound FIFO and hand it to the master port. Read jobs push data returned by the bus into an inbound FIFO.

The master port cannot stall, so the engine tells it ahead of time when the burst is about to end. It does this with two hint outputs: one meaning a single dword is left, and one meaning two or fewer are left. The direction mode and the bus request stay asserted until the port reports that the burst has finished. When both a read job and a write job are pending, a selectable policy decides which one runs next. A job ends either normally or on a target abort or timeout. Each outcome leaves a sticky status bit, and an interrupt is raised if it is enabled.

Top module: `dma_bm_engine`

## Requirements
- R1: After reset, every register reads zero. The mode, request, hint, FIFO strobe and interrupt outputs are all low.
- R2: The register index on `reg_addr` selects the register. 0 is the read address, 1 is the write address, and 2 holds the lengths, with the write length in bits 31:16 and the read length in bits 15:0, counted in dwords. 3 is control/status, laid out as follows. Bit 0 starts a read and bit 1 starts a write. Bit 2 enables the interrupt and bit 3 selects read-first arbitration. Bits 5:4 hold the read command and bits 15:8 the burst length. Bits 16, 17 and 18 are the sticky done, abort and timeout flags, and bit 19 reads back busy.
- R3: A job raises exactly one mode output, the one for its direction. That mode stays high until the done input for that direction returns for the job's final burst, and it stays high between the bursts of the job.
- R4: The request stays low while the first data item is unavailable: for a write, while the outbound FIFO is empty; for a read, while the inbound FIFO is full. Once raised, the request stays high until that direction's done input arrives.
- R5: During a burst, the one-left hint is high exactly when one dword of the burst remains. The two-or-fewer hint is high exactly when one or two remain.
- R6: Each dword transferred adds 4 to the active address and subtracts 1 from that direction's length register. For a write, a transfer is counted on each write acknowledge. For a read, it is counted on each transferred-last-clock pulse.
- R7: The read command output always equals control bits 5:4. Codes 00 and 01 select Memory Read, 10 selects Memory Read Line and 11 selects Memory Read Multiple.
- R8: During a write job, the outbound FIFO pop equals the write acknowledge, and the write data is the FIFO head. During a read job, the inbound FIFO push equals the read-valid input, and the pushed data is the read data.
- R9: A nonzero burst length N splits a job into bursts of at most N dwords. The request drops after each burst's done and is raised again for the next burst. A burst length of 0 runs the whole job as one burst.
- R10: When read and write starts are both pending, the read runs first if bit 3 is 1. If bit 3 is 0, the direction opposite to the last job served runs first, and the first job after reset counts as a read.
- R11: A target abort or target timeout seen during a burst ends the job at that burst's done. The abort or timeout flag is set together with done, no further request is made, and the length register keeps the count not transferred.
- R12: A start bit clears itself when its job begins. A start with a zero length completes at once with done and no mode. The status flags clear only when 1 is written to them. The interrupt is high while it is enabled and any status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| wf_rdata | input | 32 | Outbound FIFO head |
| wf_empty | input | 1 | Outbound FIFO empty |
| wf_pop | output | 1 | Outbound FIFO pop |
| rf_wdata | output | 32 | Inbound FIFO write data |
| rf_full | input | 1 | Inbound FIFO full |
| rf_push | output | 1 | Inbound FIFO push |
| m_rd_addr | output | 32 | Current read address |
| m_wr_addr | output | 32 | Current write address |
| m_rd_mode | output | 1 | Read job in progress |
| m_wr_mode | output | 1 | Write job in progress |
| m_req | output | 1 | Bus request |
| m_one_left | output | 1 | One dword left in burst |
| m_two_left | output | 1 | Two or fewer dwords left in burst |
| m_rd_cmd | output | 2 | Read command type |
| m_wr_data | output | 32 | Write data to master port |
| m_wr_valid | output | 1 | Write data valid |
| m_wr_ack | input | 1 | Write data taken by the port |
| m_wr_done | input | 1 | Write burst finished |
| m_rd_data | input | 32 | Read data from the port |
| m_rd_valid | input | 1 | Read data valid |
| m_rd_done | input | 1 | Read burst finished |
| m_xfer_d1 | input | 1 | A transfer happened on the previous clock |
| m_tabort | input | 1 | Target abort detected |
| m_ttimeout | input | 1 | Target timeout detected |

## Verification
The hardest situation to reach is a multi-burst read. In that case the count is driven by a delayed transfer pulse rather than by the data strobe. Between bursts the request must drop while the mode holds, and the hints must restart for the shorter final burst. The bench gets there with a five-dword job, a burst length of two and a port model that pulses valid, then the delayed transfer pulse, then done. At each step it checks that the hints, request and mode follow the count. Errors are injected mid-burst, before the done pulse, and arbitration is driven with both starts written in the same register write.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;
  localparam int LEN_W  = 16;
  localparam int BLEN_W = 8;

  localparam logic [1:0] RI_RADDR = 2'd0;
  localparam logic [1:0] RI_WADDR = 2'd1;
  localparam logic [1:0] RI_LEN   = 2'd2;
  localparam logic [1:0] RI_CTRL  = 2'd3;

  localparam int C_GO_RD    = 0;
  localparam int C_GO_WR    = 1;
  localparam int C_IRQ_EN   = 2;
  localparam int C_RD_FIRST = 3;
  localparam int C_CMD_LO   = 4;
  localparam int C_BLEN_LO  = 8;
  localparam int C_DONE     = 16;
  localparam int C_ABORT    = 17;
  localparam int C_TTO      = 18;
  localparam int C_BUSY     = 19;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_BURST} xfer_st_e;
endpackage

// File: rtl/dma_bm_arb.sv
module dma_bm_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pend,
  input  logic wr_pend,
  input  logic rd_first,
  input  logic take,
  output logic grant_vld,
  output logic grant_wr
);
  logic last_wr_q;

  always_comb begin
    grant_vld = rd_pend | wr_pend;
    if (rd_pend && wr_pend) grant_wr = rd_first ? 1'b0 : ~last_wr_q;
    else                    grant_wr = wr_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_wr_q <= 1'b0;
    else if (take) last_wr_q <= grant_wr;
  end

  // R10
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (grant_wr ? wr_pend : rd_pend));
endmodule

// File: rtl/dma_bm_burst.sv
module dma_bm_burst import dma_bm_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_wr,
  input  logic [LEN_W-1:0]  rlen,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [BLEN_W-1:0] blen,
  input  logic              rd_room,
  input  logic              wr_avail,
  input  logic              wr_ack,
  input  logic              xfer_d1,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              tabort,
  input  logic              ttimeout,
  output logic              take,
  output logic              busy,
  output logic              dir_wr,
  output logic              step,
  output logic              fin,
  output logic              fin_ab,
  output logic              fin_to,
  output logic              rd_mode,
  output logic              wr_mode,
  output logic              req,
  output logic              one_left,
  output logic              two_left
);
  xfer_st_e         st_q, st_d;
  logic             dir_q, dir_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic             eab_q, eab_d, eto_q, eto_d;
  logic [LEN_W-1:0] job_rem, go_len, rem_after, burst_len, blen_x;
  logic             in_burst, done_in, ab_now, to_now, ready, job_end;

  always_comb begin
    in_burst  = (st_q == ST_BURST);
    job_rem   = dir_q ? wlen : rlen;
    go_len    = go_wr ? wlen : rlen;
    blen_x    = {{(LEN_W-BLEN_W){1'b0}}, blen};
    burst_len = ((blen == '0) || (job_rem < blen_x)) ? job_rem : blen_x;
    step      = in_burst && (bcnt_q != '0) && (dir_q ? wr_ack : xfer_d1);
    rem_after = job_rem - {{(LEN_W-1){1'b0}}, step};
    done_in   = dir_q ? wr_done : rd_done;
    ab_now    = eab_q | (in_burst & tabort);
    to_now    = eto_q | (in_burst & ttimeout);
    ready     = dir_q ? wr_avail : rd_room;
    job_end   = ab_now | to_now | (rem_after == '0);
    take      = (st_q == ST_IDLE) && go;
    fin       = (take && (go_len == '0)) || (in_burst && done_in && job_end);
    fin_ab    = in_burst && done_in && ab_now;
    fin_to    = in_burst && done_in && to_now;
    eab_d     = in_burst & ~done_in & ab_now;
    eto_d     = in_burst & ~done_in & to_now;
    st_d      = st_q;
    dir_d     = dir_q;
    bcnt_d    = bcnt_q;
    case (st_q)
      ST_IDLE: if (take && (go_len != '0)) begin
        st_d  = ST_ARM;
        dir_d = go_wr;
      end
      ST_ARM: if (ready) begin
        st_d   = ST_BURST;
        bcnt_d = burst_len;
      end
      ST_BURST: begin
        bcnt_d = bcnt_q - {{(LEN_W-1){1'b0}}, step};
        if (done_in) st_d = job_end ? ST_IDLE : ST_ARM;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      bcnt_q <= '0;
      eab_q  <= 1'b0;
      eto_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      bcnt_q <= bcnt_d;
      eab_q  <= eab_d;
      eto_q  <= eto_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign dir_wr   = dir_q;
  assign wr_mode  = busy & dir_q;
  assign rd_mode  = busy & ~dir_q;
  assign req      = in_burst;
  assign one_left = in_burst && (bcnt_q == {{(LEN_W-1){1'b0}}, 1'b1});
  assign two_left = in_burst && (bcnt_q != '0) && (bcnt_q <= LEN_W'(2));

  // R3
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_mode && wr_mode));
  // R3
  wr_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_mode) |-> $past(wr_done));
  // R3
  rd_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_mode) |-> $past(rd_done));
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(wr_done || rd_done));
  // R5
  hint_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    one_left |-> two_left);
  // R5
  hint_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_left && step) |=> !two_left);
endmodule

// File: rtl/dma_bm_engine.sv
module dma_bm_engine import dma_bm_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic [DW-1:0] wf_rdata,
  input  logic          wf_empty,
  output logic          wf_pop,
  output logic [DW-1:0] rf_wdata,
  input  logic          rf_full,
  output logic          rf_push,
  output logic [DW-1:0] m_rd_addr,
  output logic [DW-1:0] m_wr_addr,
  output logic          m_rd_mode,
  output logic          m_wr_mode,
  output logic          m_req,
  output logic          m_one_left,
  output logic          m_two_left,
  output logic [1:0]    m_rd_cmd,
  output logic [DW-1:0] m_wr_data,
  output logic          m_wr_valid,
  input  logic          m_wr_ack,
  input  logic          m_wr_done,
  input  logic [DW-1:0] m_rd_data,
  input  logic          m_rd_valid,
  input  logic          m_rd_done,
  input  logic          m_xfer_d1,
  input  logic          m_tabort,
  input  logic          m_ttimeout
);
  localparam logic [DW-1:0] ADDR_STEP = DW'(4);

  logic [DW-1:0]     rad_q, rad_d, wad_q, wad_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d, wlen_q, wlen_d;
  logic              gord_q, gord_d, gowr_q, gowr_d, irqen_q, irqen_d, rdf_q, rdf_d;
  logic [1:0]        cmd_q, cmd_d;
  logic [BLEN_W-1:0] blen_q, blen_d;
  logic              sdone_q, sdone_d, sab_q, sab_d, sto_q, sto_d;
  logic              grant_vld, grant_wr, take, busy, dir_wr, step, fin, fin_ab, fin_to;
  logic              w_ctrl;

  dma_bm_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rd_pend(gord_q), .wr_pend(gowr_q),
    .rd_first(rdf_q), .take(take), .grant_vld(grant_vld), .grant_wr(grant_wr)
  );

  dma_bm_burst u_burst (
    .clk(clk), .rst_n(rst_n), .go(grant_vld), .go_wr(grant_wr),
    .rlen(rlen_q), .wlen(wlen_q), .blen(blen_q),
    .rd_room(~rf_full), .wr_avail(~wf_empty), .wr_ack(m_wr_ack), .xfer_d1(m_xfer_d1),
    .wr_done(m_wr_done), .rd_done(m_rd_done), .tabort(m_tabort), .ttimeout(m_ttimeout),
    .take(take), .busy(busy), .dir_wr(dir_wr), .step(step),
    .fin(fin), .fin_ab(fin_ab), .fin_to(fin_to),
    .rd_mode(m_rd_mode), .wr_mode(m_wr_mode), .req(m_req),
    .one_left(m_one_left), .two_left(m_two_left)
  );

  always_comb begin
    w_ctrl  = reg_wr && (reg_addr == RI_CTRL);
    rad_d   = rad_q;
    wad_d   = wad_q;
    rlen_d  = rlen_q;
    wlen_d  = wlen_q;
    if (step && !dir_wr) begin
      rad_d  = rad_q + ADDR_STEP;
      rlen_d = rlen_q - 1'b1;
    end
    if (step && dir_wr) begin
      wad_d  = wad_q + ADDR_STEP;
      wlen_d = wlen_q - 1'b1;
    end
    if (reg_wr && (reg_addr == RI_RADDR)) rad_d = reg_wdata;
    if (reg_wr && (reg_addr == RI_WADDR)) wad_d = reg_wdata;
    if (reg_wr && (reg_addr == RI_LEN)) begin
      rlen_d = reg_wdata[LEN_W-1:0];
      wlen_d = reg_wdata[2*LEN_W-1:LEN_W];
    end
    gord_d  = gord_q & ~(take & ~grant_wr);
    gowr_d  = gowr_q & ~(take & grant_wr);
    irqen_d = irqen_q;
    rdf_d   = rdf_q;
    cmd_d   = cmd_q;
    blen_d  = blen_q;
    if (w_ctrl) begin
      gord_d  = reg_wdata[C_GO_RD];
      gowr_d  = reg_wdata[C_GO_WR];
      irqen_d = reg_wdata[C_IRQ_EN];
      rdf_d   = reg_wdata[C_RD_FIRST];
      cmd_d   = reg_wdata[C_CMD_LO +: 2];
      blen_d  = reg_wdata[C_BLEN_LO +: BLEN_W];
    end
    sdone_d = (sdone_q & ~(w_ctrl & reg_wdata[C_DONE]))  | fin;
    sab_d   = (sab_q   & ~(w_ctrl & reg_wdata[C_ABORT])) | fin_ab;
    sto_d   = (sto_q   & ~(w_ctrl & reg_wdata[C_TTO]))   | fin_to;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q <= '0;  wad_q <= '0;  rlen_q <= '0;  wlen_q <= '0;
      gord_q <= 1'b0;  gowr_q <= 1'b0;  irqen_q <= 1'b0;  rdf_q <= 1'b0;
      cmd_q <= '0;  blen_q <= '0;
      sdone_q <= 1'b0;  sab_q <= 1'b0;  sto_q <= 1'b0;
    end else begin
      rad_q <= rad_d;  wad_q <= wad_d;  rlen_q <= rlen_d;  wlen_q <= wlen_d;
      gord_q <= gord_d;  gowr_q <= gowr_d;  irqen_q <= irqen_d;  rdf_q <= rdf_d;
      cmd_q <= cmd_d;  blen_q <= blen_d;
      sdone_q <= sdone_d;  sab_q <= sab_d;  sto_q <= sto_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_RADDR: reg_rdata = rad_q;
      RI_WADDR: reg_rdata = wad_q;
      RI_LEN:   reg_rdata[2*LEN_W-1:0] = {wlen_q, rlen_q};
      default: begin
        reg_rdata[C_GO_RD]               = gord_q;
        reg_rdata[C_GO_WR]               = gowr_q;
        reg_rdata[C_IRQ_EN]              = irqen_q;
        reg_rdata[C_RD_FIRST]            = rdf_q;
        reg_rdata[C_CMD_LO +: 2]         = cmd_q;
        reg_rdata[C_BLEN_LO +: BLEN_W]   = blen_q;
        reg_rdata[C_DONE]                = sdone_q;
        reg_rdata[C_ABORT]               = sab_q;
        reg_rdata[C_TTO]                 = sto_q;
        reg_rdata[C_BUSY]                = busy;
      end
    endcase
  end

  assign irq        = irqen_q & (sdone_q | sab_q | sto_q);
  assign m_rd_addr  = rad_q;
  assign m_wr_addr  = wad_q;
  assign m_rd_cmd   = cmd_q;
  assign m_wr_data  = wf_rdata;
  assign m_wr_valid = m_wr_mode & ~wf_empty;
  assign wf_pop     = m_wr_mode & m_wr_ack;
  assign rf_push    = m_rd_mode & m_rd_valid;
  assign rf_wdata   = m_rd_data;

  // R11
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sab_q) || $rose(sto_q)) |-> $rose(sdone_q) || sdone_q);
  // R8
  pop_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wf_pop && rf_push));
endmodule

// File: tb/dma_bm_engine_bench.sv
module dma_bm_engine_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;
  logic [31:0] wf_rdata, rf_wdata, m_rd_addr, m_wr_addr, m_wr_data, m_rd_data;
  logic        wf_empty, wf_pop, rf_full, rf_push;
  logic        m_rd_mode, m_wr_mode, m_req, m_one_left, m_two_left, m_wr_valid;
  logic [1:0]  m_rd_cmd;
  logic        m_wr_ack, m_wr_done, m_rd_valid, m_rd_done, m_xfer_d1, m_tabort, m_ttimeout;

  int vec = 0;
  int bad = 0;
  logic [31:0] v;

  always #(CLK_P/2) clk = ~clk;

  dma_bm_engine u_dma_bm_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .wf_rdata(wf_rdata), .wf_empty(wf_empty), .wf_pop(wf_pop),
    .rf_wdata(rf_wdata), .rf_full(rf_full), .rf_push(rf_push),
    .m_rd_addr(m_rd_addr), .m_wr_addr(m_wr_addr), .m_rd_mode(m_rd_mode),
    .m_wr_mode(m_wr_mode), .m_req(m_req), .m_one_left(m_one_left),
    .m_two_left(m_two_left), .m_rd_cmd(m_rd_cmd), .m_wr_data(m_wr_data),
    .m_wr_valid(m_wr_valid), .m_wr_ack(m_wr_ack), .m_wr_done(m_wr_done),
    .m_rd_data(m_rd_data), .m_rd_valid(m_rd_valid), .m_rd_done(m_rd_done),
    .m_xfer_d1(m_xfer_d1), .m_tabort(m_tabort), .m_ttimeout(m_ttimeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit gr, input bit gw, input bit ie,
                                      input bit rf, input logic [1:0] cmd,
                                      input logic [7:0] bl);
    return {13'b0, 3'b111, bl, 2'b00, cmd, rf, ie, gw, gr};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_req(input string tag);
    for (int i = 0; i < 20 && !m_req; i++) @(negedge clk);
    chk(tag, m_req, 1'b1);
  endtask

  task automatic wr_xfer(input int rem, input string tag);
    chk({tag, " one_left"}, m_one_left, rem == 1);
    chk({tag, " two_left"}, m_two_left, rem <= 2);
    m_wr_ack = 1'b1; #1;
    chk({tag, " R8 pop"}, wf_pop, 1'b1);
    chk({tag, " R8 wdata"}, m_wr_data, wf_rdata);
    @(negedge clk); m_wr_ack = 1'b0;
  endtask

  task automatic rd_xfer(input int rem, input logic [31:0] d, input string tag);
    chk({tag, " one_left"}, m_one_left, rem == 1);
    chk({tag, " two_left"}, m_two_left, rem <= 2);
    m_rd_valid = 1'b1; m_rd_data = d; #1;
    chk({tag, " R8 push"}, rf_push, 1'b1);
    chk({tag, " R8 rdata"}, rf_wdata, d);
    @(negedge clk); m_rd_valid = 1'b0; m_xfer_d1 = 1'b1;
    @(negedge clk); m_xfer_d1 = 1'b0;
  endtask

  task automatic done_pulse(input bit wr);
    if (wr) m_wr_done = 1'b1; else m_rd_done = 1'b1;
    @(negedge clk); m_wr_done = 1'b0; m_rd_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", {m_rd_mode, m_wr_mode, m_req}, 0);
    chk("R1 hints", {m_one_left, m_two_left, irq, wf_pop, rf_push}, 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_write;
    wf_empty = 1'b1;
    wr_reg(2'd1, 32'h0000_1000);
    wr_reg(2'd2, {16'd3, 16'd0});
    wr_reg(2'd3, ctl(0, 1, 1, 0, 2'b00, 8'd0));
    @(negedge clk);
    chk("R3 wr mode up", {m_wr_mode, m_rd_mode}, 2'b10);
    chk("R4 no req while empty", m_req, 1'b0);
    rd_reg(2'd3, v);
    chk("R12 go_wr self clear", v[1], 1'b0);
    chk("R2 busy bit", v[19], 1'b1);
    wf_empty = 1'b0;
    wait_req("R4 write req");
    for (int r = 3; r >= 1; r--) wr_xfer(r, "R5 write");
    chk("R4 req held before done", m_req, 1'b1);
    chk("R3 mode held before done", m_wr_mode, 1'b1);
    chk("R5 hints zero", {m_one_left, m_two_left}, 2'b00);
    chk("R6 wr addr", m_wr_addr, 32'h0000_100C);
    rd_reg(2'd2, v);
    chk("R6 wlen", v[31:16], 0);
    done_pulse(1);
    chk("R3 mode dropped", {m_wr_mode, m_req}, 2'b00);
    chk("R12 irq", irq, 1'b1);
    rd_reg(2'd3, v);
    chk("R12 done bit", v[16], 1'b1);
    wr_reg(2'd3, ctl(0, 0, 1, 0, 2'b00, 8'd0));
    chk("R12 w1c irq", irq, 1'b0);
  endtask

  task automatic t_read_split;
    wr_reg(2'd0, 32'h0000_2000);
    wr_reg(2'd2, {16'd0, 16'd5});
    wr_reg(2'd3, ctl(1, 0, 0, 0, 2'b10, 8'd2));
    wait_req("R9 burst1 req");
    chk("R7 rd cmd", m_rd_cmd, 2'b10);
    chk("R3 rd mode", {m_wr_mode, m_rd_mode}, 2'b01);
    rd_xfer(2, 32'h11, "R9 b1");
    rd_xfer(1, 32'h22, "R9 b1");
    chk("R9 b1 req held", m_req, 1'b1);
    done_pulse(0);
    chk("R9 req drop between bursts", m_req, 1'b0);
    chk("R3 mode held between bursts", m_rd_mode, 1'b1);
    wait_req("R9 burst2 req");
    rd_xfer(2, 32'h33, "R9 b2");
    rd_xfer(1, 32'h44, "R9 b2");
    done_pulse(0);
    wait_req("R9 burst3 req");
    rd_xfer(1, 32'h55, "R9 b3");
    done_pulse(0);
    chk("R9 end mode", {m_rd_mode, m_req}, 2'b00);
    chk("R6 rd addr", m_rd_addr, 32'h0000_2014);
  endtask

  task automatic one_job(input bit wr, input string tag);
    wait_req(tag);
    chk({tag, " R10 dir"}, {m_wr_mode, m_rd_mode}, wr ? 2'b10 : 2'b01);
    if (wr) wr_xfer(1, tag); else rd_xfer(1, 32'h99, tag);
    done_pulse(wr);
  endtask

  task automatic t_arb;
    wr_reg(2'd2, {16'd1, 16'd1});
    wr_reg(2'd3, ctl(1, 1, 0, 1, 2'b00, 8'd0));
    one_job(0, "R10 prio first");
    one_job(1, "R10 prio second");
    wr_reg(2'd2, {16'd0, 16'd1});
    wr_reg(2'd3, ctl(1, 0, 0, 0, 2'b00, 8'd0));
    one_job(0, "R10 lone read");
    wr_reg(2'd2, {16'd1, 16'd1});
    wr_reg(2'd3, ctl(1, 1, 0, 0, 2'b00, 8'd0));
    one_job(1, "R10 alt first");
    one_job(0, "R10 alt second");
  endtask

  task automatic t_errors;
    wr_reg(2'd2, {16'd4, 16'd3});
    wr_reg(2'd3, ctl(0, 1, 0, 0, 2'b00, 8'd0));
    wait_req("R11 abort req");
    wr_xfer(4, "R11 abort");
    m_tabort = 1'b1;
    @(negedge clk); m_tabort = 1'b0;
    done_pulse(1);
    repeat (3) @(negedge clk);
    chk("R11 abort ends", {m_wr_mode, m_req}, 2'b00);
    rd_reg(2'd3, v);
    chk("R11 abort flags", v[18:16], 3'b011);
    rd_reg(2'd2, v);
    chk("R11 wlen kept", v[31:16], 3);
    wr_reg(2'd3, ctl(1, 0, 0, 0, 2'b00, 8'd0));
    wait_req("R11 tto req");
    m_ttimeout = 1'b1;
    done_pulse(0);
    m_ttimeout = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 tto ends", {m_rd_mode, m_req}, 2'b00);
    rd_reg(2'd3, v);
    chk("R11 tto flags", v[18:16], 3'b101);
    rd_reg(2'd2, v);
    chk("R11 rlen kept", v[15:0], 3);
  endtask

  task automatic t_zero_len;
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd3, ctl(1, 0, 0, 0, 2'b11, 8'd0));
    chk("R7 cmd 11", m_rd_cmd, 2'b11);
    @(negedge clk);
    chk("R12 zero len no mode", {m_rd_mode, m_req}, 2'b00);
    rd_reg(2'd3, v);
    chk("R12 zero len done", {v[16], v[0]}, 2'b10);
    chk("R12 irq masked", irq, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    wf_rdata = 32'hCAFE_0001; wf_empty = 1'b0; rf_full = 1'b0;
    m_wr_ack = 1'b0; m_wr_done = 1'b0; m_rd_data = '0; m_rd_valid = 1'b0;
    m_rd_done = 1'b0; m_xfer_d1 = 1'b0; m_tabort = 1'b0; m_ttimeout = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_split();
    t_arb();
    t_errors();
    t_zero_len();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule